// File: doc/BRIEF.md
# Banked Host Register Interface

This block is the slave side of a 16-bit microprocessor bus. It connects to a register file split into three banks. Two static mode pins set the bus flavour at run time. One pin chooses between a pair of separate read and write strobes and a read/write direction level with a single data strobe. The other pin chooses whether the word address comes from dedicated address pins or from the low data lines. In the second case an address-latch strobe captures the address first.

The bus inputs are brought into the core clock domain through two-stage synchronisers. An access commits on the trailing edge of the active strobe while chip select is low. Eight common word slots are visible from every bank, and so is a bank-select slot at the top of the map. The remaining slots hold one copy per bank. One common slot behaves differently on write and on read. A write there sets the interrupt enable mask. A read there returns the pending interrupt code, and the read clears the bits it returned once the strobe ends.

Top module: `hostreg_bank`

## Requirements
- R1: After reset the selected bank is 0, the mask and the pending code are 0, int_o is 0, data_oe is 0 and every storage register reads 0.
- R2: With strobe_mode=0, an access is a read while rd_n is low and a write while wr_n is low. It takes effect only while cs_n is low, and a write commits when the strobe rises.
- R3: With strobe_mode=1, wr_n is the data strobe and rd_n gives the direction: 1 means read, 0 means write.
- R4: With addr_mode=0, the word index is taken from addr_in, which carries byte address bits 5..1.
- R5: With addr_mode=1, the word index is taken from data_in[5:1] while ale is high and is held after ale falls. addr_in is ignored in this mode.
- R6: Writing 0, 1 or 2 to index 31 selects that bank, and any other value leaves the bank unchanged. A read of index 31 returns the bank in bits 1:0 and zeros above.
- R7: Indices 8 to 30 are 16-bit storage with an independent copy in each bank.
- R8: Indices 0, 2, 4, 5, 6 and 7 are 16-bit storage shared by all banks.
- R9: A write to index 3 loads the interrupt mask. A read of index 3 returns the pending code, not the mask.
- R10: A read of index 1 returns bank in bits 1:0, int_o in bit 2 and zeros above. Writes to index 1 have no effect.
- R11: Each bit of irq_evt that is high in a clock cycle sets the matching pending bit. int_o is high exactly when some pending bit is also enabled in the mask.
- R12: A read of index 3 returns the pending snapshot taken before the strobe was seen. When that read ends, exactly the bits it returned are cleared. Events arriving during the strobe, or in the cycle the clear happens, are kept.
- R13: data_oe is high only during a qualified read strobe. data_out is 0 whenever data_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_mode | input | 1 | 0: separate read and write strobes; 1: direction level plus data strobe |
| addr_mode | input | 1 | 0: dedicated address pins; 1: address on data_in[5:1], latched by ale |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Read strobe, or direction level (1 = read) |
| wr_n | input | 1 | Write strobe, or data strobe, active low |
| addr_in | input | 5 | Word index, byte address bits 5..1 |
| data_in | input | 16 | Write data, and address in multiplexed mode |
| irq_evt | input | 16 | Interrupt event pulses, synchronous to clk |
| data_out | output | 16 | Read data |
| data_oe | output | 1 | Read data driver enable |
| int_o | output | 1 | Interrupt request, active high |

## Verification
Two functions can land in the same cycle: the clear that ends a read of the pending code, and the setting of a pending bit by a fresh interrupt event. To provoke this, a new event bit is fired at each offset from three cycles before the strobe is released to five cycles after. One of those offsets falls on the synchronised trailing edge. For every offset the read must return only the old bits. A following read must then return exactly the new bit, and a third read must return zero. The register sweeps are run in all four combinations of the two mode pins.

// File: rtl/hostreg_bank.sv
module hostreg_bank #(
  parameter int DW      = 16,
  parameter int AW      = 5,
  parameter int NBANK   = 3,
  parameter int NCOMMON = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_mode,
  input  logic          addr_mode,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] irq_evt,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          int_o
);
  localparam int BSEL = (1 << AW) - 1;
  localparam int NBR  = BSEL - NCOMMON;
  localparam int BW   = $clog2(NBANK);
  localparam int CW   = $clog2(NCOMMON);
  localparam int IW   = $clog2(NBANK * NBR);
  localparam int STAT = 1;
  localparam int IRQ  = 3;

  logic [1:0]    cs_p, rd_p, wr_p, ale_p;
  logic [AW-1:0] a_p1, a_p2, alat, cap_addr;
  logic [DW-1:0] d_p1, d_p2, cap_data;
  logic          act_q, cap_rd;
  logic [BW-1:0] bank;
  logic [DW-1:0] mask, pend, hold, rdata;
  logic [DW-1:0] creg [NCOMMON];
  logic [DW-1:0] breg [NBANK*NBR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '1; rd_p <= '1; wr_p <= '1; ale_p <= '0;
      a_p1 <= '0; a_p2 <= '0; d_p1 <= '0; d_p2 <= '0;
    end else begin
      cs_p  <= {cs_p[0], cs_n};
      rd_p  <= {rd_p[0], rd_n};
      wr_p  <= {wr_p[0], wr_n};
      ale_p <= {ale_p[0], ale};
      a_p1 <= addr_in; a_p2 <= a_p1;
      d_p1 <= data_in; d_p2 <= d_p1;
    end
  end

  wire act   = ~cs_p[1] & (strobe_mode ? ~wr_p[1] : (~rd_p[1] | ~wr_p[1]));
  wire is_rd = strobe_mode ? rd_p[1] : ~rd_p[1];
  wire [AW-1:0] cur_addr = addr_mode ? alat : a_p2;
  wire trail = act_q & ~act;
  wire wr_ev = trail & ~cap_rd;
  wire rd_ev = trail & cap_rd;
  wire clr_code = rd_ev && (cap_addr == AW'(IRQ));

  wire [IW-1:0] widx = IW'(int'(bank) * NBR + int'(cap_addr) - NCOMMON);
  wire [IW-1:0] ridx = IW'(int'(bank) * NBR + int'(cur_addr) - NCOMMON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alat <= '0; act_q <= 1'b0; cap_rd <= 1'b0; cap_addr <= '0; cap_data <= '0;
    end else begin
      if (ale_p[1]) alat <= d_p2[AW:1];
      act_q <= act;
      if (act) begin
        cap_rd   <= is_rd;
        cap_addr <= cur_addr;
        cap_data <= d_p2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
      mask <= '0;
      for (int i = 0; i < NCOMMON; i++) creg[i] <= '0;
      for (int i = 0; i < NBANK*NBR; i++) breg[i] <= '0;
    end else if (wr_ev) begin
      if (cap_addr == AW'(BSEL)) begin
        if (cap_data < DW'(NBANK)) bank <= cap_data[BW-1:0];
      end else if (cap_addr == AW'(IRQ)) begin
        mask <= cap_data;
      end else if (cap_addr == AW'(STAT)) begin
        bank <= bank;
      end else if (cap_addr < AW'(NCOMMON)) begin
        creg[cap_addr[CW-1:0]] <= cap_data;
      end else begin
        breg[widx] <= cap_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      hold <= '0;
    end else begin
      if (!act) hold <= pend;
      pend <= (pend & ~(clr_code ? hold : '0)) | irq_evt;
    end
  end

  assign int_o = |(pend & mask);

  always_comb begin
    rdata = '0;
    if (cur_addr == AW'(BSEL)) begin
      rdata[BW-1:0] = bank;
    end else if (cur_addr == AW'(STAT)) begin
      rdata[BW-1:0] = bank;
      rdata[BW]     = int_o;
    end else if (cur_addr == AW'(IRQ)) begin
      rdata = hold;
    end else if (cur_addr < AW'(NCOMMON)) begin
      rdata = creg[cur_addr[CW-1:0]];
    end else begin
      rdata = breg[ridx];
    end
  end

  assign data_oe  = act & is_rd;
  assign data_out = data_oe ? rdata : '0;

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !$past(cs_n, 2)); // R13

  AST_BANK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ev |=> $stable(bank)); // R6

  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bank) < NBANK); // R6

  AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> $past(wr_ev && cap_addr == AW'(IRQ))); // R9

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_evt) |=> ((pend & $past(irq_evt)) == $past(irq_evt))); // R11

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_code && irq_evt == '0) |=> ((pend & $past(hold)) == '0)); // R12
endmodule

// File: tb/hostreg_bank_tb.sv
module hostreg_bank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe_mode = 1'b0, addr_mode = 1'b0;
  logic cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [4:0]  addr_in = '0;
  logic [15:0] data_in = '0, irq_evt = '0;
  logic [15:0] data_out;
  logic data_oe, int_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hostreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_mode(strobe_mode), .addr_mode(addr_mode),
    .cs_n(cs_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_in(addr_in),
    .data_in(data_in), .irq_evt(irq_evt), .data_out(data_out),
    .data_oe(data_oe), .int_o(int_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit rd, input logic [4:0] ad, input logic [15:0] wd,
                     input bit csq, input int evt_at, input logic [15:0] ev,
                     output logic [15:0] q, output logic oe);
    @(negedge clk);
    if (addr_mode) begin
      addr_in = ~ad;
      data_in = {10'b0, ad, 1'b0};
      ale = 1'b1;
      repeat (4) @(negedge clk);
      ale = 1'b0;
      repeat (3) @(negedge clk);
    end else begin
      addr_in = ad;
      ale = 1'b0;
    end
    data_in = rd ? 16'hA5C3 : wd;
    cs_n = csq;
    if (strobe_mode) begin
      rd_n = rd;
      @(negedge clk);
      wr_n = 1'b0;
    end else if (rd) rd_n = 1'b0;
    else wr_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = -3; k < 0; k++) begin
      if (k == evt_at) irq_evt = ev;
      @(negedge clk);
      irq_evt = '0;
    end
    q = data_out;
    oe = data_oe;
    wr_n = 1'b1;
    if (!strobe_mode) rd_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      if (k == evt_at) irq_evt = ev;
      @(negedge clk);
      irq_evt = '0;
    end
    cs_n = 1'b1;
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] ad, input logic [15:0] wd);
    logic [15:0] q; logic oe;
    bus(1'b0, ad, wd, 1'b0, 99, '0, q, oe);
    chk("R13 write oe", {15'b0, oe}, 16'h0);
    chk("R13 write data_out", q, 16'h0);
  endtask

  task automatic rdv(input logic [4:0] ad, output logic [15:0] q);
    logic oe;
    bus(1'b1, ad, '0, 1'b0, 99, '0, q, oe);
    chk("R13 read oe", {15'b0, oe}, 16'h1);
  endtask

  task automatic fire(input logic [15:0] v);
    @(negedge clk); irq_evt = v;
    @(negedge clk); irq_evt = '0;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int m, input int b, input int i);
    return 16'(m * 4096 + b * 1024 + i * 32 + (i ^ 21));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] q; logic oe; string mt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe idle", {15'b0, data_oe}, 16'h0);
    chk("R1 int_o", {15'b0, int_o}, 16'h0);
    rdv(5'd31, q); chk("R1 bank", q, 16'h0);
    rdv(5'd8, q);  chk("R1 banked reg", q, 16'h0);
    rdv(5'd0, q);  chk("R1 common reg", q, 16'h0);
    rdv(5'd3, q);  chk("R1 pending", q, 16'h0);

    for (int m = 0; m < 4; m++) begin
      strobe_mode = m[0];
      addr_mode   = m[1];
      mt = {strobe_mode ? "R3" : "R2", " ", addr_mode ? "R5" : "R4"};
      for (int b = 0; b < 3; b++) begin
        wr(5'd31, 16'(b));
        for (int i = 8; i < 31; i++) wr(5'(i), pat(m, b, i));
      end
      for (int b = 2; b >= 0; b--) begin
        wr(5'd31, 16'(b));
        rdv(5'd31, q); chk({"R6 bank ", mt}, q, 16'(b));
        for (int i = 8; i < 31; i++) begin
          rdv(5'(i), q); chk({"R7 banked ", mt}, q, pat(m, b, i));
        end
      end
      wr(5'd31, 16'd0);
      for (int i = 0; i < 8; i++)
        if (i != 1 && i != 3) wr(5'(i), pat(m, 3, i));
      for (int b = 1; b < 3; b++) begin
        wr(5'd31, 16'(b));
        for (int i = 0; i < 8; i++)
          if (i != 1 && i != 3) begin
            rdv(5'(i), q); chk({"R8 common ", mt}, q, pat(m, 3, i));
          end
      end
      wr(5'd31, 16'd3);
      rdv(5'd31, q); chk("R6 value 3 ignored", q, 16'd2);
      wr(5'd31, 16'h0101);
      rdv(5'd31, q); chk("R6 wide value ignored", q, 16'd2);
      rdv(5'd1, q); chk("R10 status", q, 16'h0002);
      wr(5'd1, 16'hFFFF);
      rdv(5'd1, q); chk("R10 status write ignored", q, 16'h0002);
      rdv(5'd31, q); chk("R10 bank after status write", q, 16'd2);
      bus(1'b0, 5'd8, 16'hDEAD, 1'b1, 99, '0, q, oe);
      rdv(5'd8, q); chk({"R2 cs high write ignored ", mt}, q, pat(m, 2, 8));
      bus(1'b1, 5'd8, '0, 1'b1, 99, '0, q, oe);
      chk("R13 cs high read oe", {15'b0, oe}, 16'h0);
      chk("R13 cs high data_out", q, 16'h0);

      wr(5'd3, 16'h00F0);
      fire(16'h0001);
      chk("R11 masked event int_o", {15'b0, int_o}, 16'h0);
      rdv(5'd3, q); chk("R9 read returns code", q, 16'h0001);
      fire(16'h0020);
      chk("R11 enabled event int_o", {15'b0, int_o}, 16'h1);
      rdv(5'd1, q); chk("R10 status int bit", q, 16'h0006);
      rdv(5'd3, q); chk("R12 code read", q, 16'h0020);
      @(negedge clk);
      chk("R12 int_o after read", {15'b0, int_o}, 16'h0);
      rdv(5'd3, q); chk("R12 cleared", q, 16'h0);

      wr(5'd3, 16'hFFFF);
      for (int k = -3; k < 6; k++) begin
        fire(16'h0003);
        bus(1'b1, 5'd3, '0, 1'b0, k, 16'h0100, q, oe);
        chk("R12 snapshot under collision", q, 16'h0003);
        rdv(5'd3, q); chk("R12 new event kept", q, 16'h0100);
        rdv(5'd3, q); chk("R12 second clear", q, 16'h0);
      end
      chk("R11 int_o idle", {15'b0, int_o}, 16'h0);
      wr(5'd3, 16'h0000);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule